// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block collects up to sixteen interrupt request lines and decides which of them the CPU should service next. Each line has its own enable bit and one level bit that places it at low or high level. A global enable masks every line at once. Slot positions that are not populated can never win.

When the CPU-side sequencer raises `cpuReady`, the block arbitrates once in that cycle. On the next cycle it emits a one-cycle acknowledge that carries the winning slot index and a fixed vector address. The slots are spaced eight bytes apart. The block keeps one in-service flag per level and uses these flags to enforce nesting. A high-level routine cannot be interrupted at all. A low-level routine can be pre-empted only by a high-level request. A return pulse from the CPU retires the highest level that is active.

The enable and level vectors come in as plain inputs. Register decoding, the CPU and the requesting peripherals all sit outside the block.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, `ackValid`, `activeHigh` and `activeLow` are all 0.
- R2: A slot is a candidate only when its `reqIn` bit, its `srcEnable` bit and `globalEnable` are all 1. A request whose enable bit is 0 is never acknowledged.
- R3: While `globalEnable` is 0, no acknowledge is produced, whatever the request and enable vectors hold.
- R4: Bit i of parameter POPULATED marks zero-based slot i as present. The default is 0x0FFF, so indices 12 to 15 (slots 13 to 16) are reserved and are never acknowledged.
- R5: A `prioHigh` bit of 1 puts that slot at high level. When candidates of both levels exist in the arbitration cycle, a high-level candidate wins.
- R6: Among candidates of the winning level, the lowest slot index wins. Index 0 (slot 1) is the first in the polling order and index 15 (slot 16) the last.
- R7: `ackSlot` is the zero-based index k of the winner. `ackVector` equals 0x0003 + 8*k, which gives 0x0003 for k=0, 0x000B for k=1 and 0x007B for k=15.
- R8: Arbitration happens only in a cycle where `cpuReady` is 1. The acknowledge appears in the following cycle and stays high for exactly that one cycle per acceptance.
- R9: While `activeHigh` is 1, no request of either level is accepted.
- R10: While only `activeLow` is 1, low-level candidates are held off. A high-level candidate is still accepted.
- R11: A `retPulse` clears `activeHigh` if it is set, and otherwise clears `activeLow`. The change shows one cycle after the pulse.
- R12: An acceptance sets the in-service flag of the winner's level. The flag shows on `activeHigh` or `activeLow` in the same cycle as the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqIn | input | 16 | Interrupt request per slot, bit i = slot i+1 |
| srcEnable | input | 16 | Per-slot enable |
| prioHigh | input | 16 | Per-slot level, 1 = high level |
| globalEnable | input | 1 | Master enable for all slots |
| cpuReady | input | 1 | CPU can take an interrupt this cycle |
| retPulse | input | 1 | Return-from-interrupt pulse |
| ackValid | output | 1 | One-cycle acknowledge strobe |
| ackSlot | output | 4 | Zero-based index of the granted slot |
| ackVector | output | 16 | Vector address of the granted slot |
| activeHigh | output | 1 | High-level routine in service |
| activeLow | output | 1 | Low-level routine in service |

## Verification
The assertions assume that `retPulse` arrives only when a level is actually in service. They also assume that the request, enable and level vectors are stable from the falling edge until the next rising edge. The bench drives every input at the falling edge. It issues return pulses only when the reference model shows an active level, and even in the random phase it keeps a matching return for each acceptance. The random phase mixes level bits, enables and reserved-slot requests, so that pre-emption, blocking and polling order all appear under these conditions.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

  // Strobes from control to datapath, one set per cycle.
  typedef struct packed {
    logic accept;     // load the acknowledge registers this cycle
    logic grantHigh;  // winner comes from the high-level picker
  } ctrlStrobe_t;

  typedef enum logic {
    LVL_LOW  = 1'b0,
    LVL_HIGH = 1'b1
  } irqLevel_e;

endpackage

// File: rtl/prio_irq_pick.sv
// Lowest-index-first picker over one level's candidate vector.
module prio_irq_pick #(
  parameter int NUM_SLOTS = 16,
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0] candBits,
  output logic                 anySet,
  output logic [IDX_W-1:0]     pickIdx
);

  always_comb begin
    pickIdx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (candBits[i]) pickIdx = IDX_W'(i);
    end
  end

  assign anySet = |candBits;

endmodule

// File: rtl/prio_irq_datapath.sv
// Masking, per-level picking, vector computation and acknowledge registers.
module prio_irq_datapath
  import prio_irq_pkg::*;
#(
  parameter int NUM_SLOTS  = 16,
  parameter int ADDR_W     = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  parameter logic [NUM_SLOTS-1:0] POPULATED = 16'h0FFF,
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SLOTS-1:0] reqIn,
  input  logic [NUM_SLOTS-1:0] srcEnable,
  input  logic [NUM_SLOTS-1:0] prioHigh,
  input  logic                 globalEnable,
  input  ctrlStrobe_t          strobe,
  output logic                 highPending,
  output logic                 lowPending,
  output logic                 ackValid,
  output logic [IDX_W-1:0]     ackSlot,
  output logic [ADDR_W-1:0]    ackVector
);

  localparam int NUM_LVL = 2;

  logic [NUM_SLOTS-1:0] candAll;
  logic [NUM_SLOTS-1:0] levelBits [NUM_LVL];
  logic [NUM_LVL-1:0]   levelAny;
  logic [IDX_W-1:0]     levelIdx  [NUM_LVL];
  logic [IDX_W-1:0]     winIdx;
  logic [ADDR_W-1:0]    winVector;

  assign candAll = reqIn & srcEnable & POPULATED & {NUM_SLOTS{globalEnable}};
  assign levelBits[LVL_LOW]  = candAll & ~prioHigh;
  assign levelBits[LVL_HIGH] = candAll & prioHigh;

  for (genvar lv = 0; lv < NUM_LVL; lv++) begin : g_level
    prio_irq_pick #(.NUM_SLOTS(NUM_SLOTS)) pick_i (
      .candBits (levelBits[lv]),
      .anySet   (levelAny[lv]),
      .pickIdx  (levelIdx[lv])
    );
  end

  assign highPending = levelAny[LVL_HIGH];
  assign lowPending  = levelAny[LVL_LOW];

  assign winIdx    = strobe.grantHigh ? levelIdx[LVL_HIGH] : levelIdx[LVL_LOW];
  assign winVector = ADDR_W'(VEC_BASE) + ADDR_W'(VEC_STRIDE) * ADDR_W'(winIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackValid  <= 1'b0;
      ackSlot   <= '0;
      ackVector <= '0;
    end else begin
      ackValid <= strobe.accept;
      if (strobe.accept) begin
        ackSlot   <= winIdx;
        ackVector <= winVector;
      end
    end
  end

endmodule

// File: rtl/prio_irq_control.sv
// In-service tracking and the acceptance decision.
module prio_irq_control
  import prio_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuReady,
  input  logic        retPulse,
  input  logic        highPending,
  input  logic        lowPending,
  output ctrlStrobe_t strobe,
  output logic        activeHigh,
  output logic        activeLow
);

  logic inSvcHigh, inSvcLow;
  logic acceptHigh, acceptLow;
  logic clrHigh, clrLow;

  // A high-level routine blocks everything; a low one blocks only its own level.
  assign acceptHigh = cpuReady & highPending & ~inSvcHigh;
  assign acceptLow  = cpuReady & lowPending & ~highPending & ~inSvcHigh & ~inSvcLow;

  // A return retires the highest active level.
  assign clrHigh = retPulse & inSvcHigh;
  assign clrLow  = retPulse & ~inSvcHigh & inSvcLow;

  always_comb begin
    strobe.accept    = acceptHigh | acceptLow;
    strobe.grantHigh = acceptHigh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inSvcHigh <= 1'b0;
      inSvcLow  <= 1'b0;
    end else begin
      inSvcHigh <= (inSvcHigh & ~clrHigh) | acceptHigh;
      inSvcLow  <= (inSvcLow & ~clrLow) | acceptLow;
    end
  end

  assign activeHigh = inSvcHigh;
  assign activeLow  = inSvcLow;

endmodule

// File: rtl/prio_irq_ctrl.sv
// Top: thin wrapper joining control and datapath.
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_SLOTS  = 16,
  parameter int ADDR_W     = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  parameter logic [NUM_SLOTS-1:0] POPULATED = 16'h0FFF,
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SLOTS-1:0] reqIn,
  input  logic [NUM_SLOTS-1:0] srcEnable,
  input  logic [NUM_SLOTS-1:0] prioHigh,
  input  logic                 globalEnable,
  input  logic                 cpuReady,
  input  logic                 retPulse,
  output logic                 ackValid,
  output logic [IDX_W-1:0]     ackSlot,
  output logic [ADDR_W-1:0]    ackVector,
  output logic                 activeHigh,
  output logic                 activeLow
);

  ctrlStrobe_t strobe;
  logic        highPending, lowPending;

  prio_irq_control ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .cpuReady    (cpuReady),
    .retPulse    (retPulse),
    .highPending (highPending),
    .lowPending  (lowPending),
    .strobe      (strobe),
    .activeHigh  (activeHigh),
    .activeLow   (activeLow)
  );

  prio_irq_datapath #(
    .NUM_SLOTS  (NUM_SLOTS),
    .ADDR_W     (ADDR_W),
    .VEC_BASE   (VEC_BASE),
    .VEC_STRIDE (VEC_STRIDE),
    .POPULATED  (POPULATED)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .reqIn        (reqIn),
    .srcEnable    (srcEnable),
    .prioHigh     (prioHigh),
    .globalEnable (globalEnable),
    .strobe       (strobe),
    .highPending  (highPending),
    .lowPending   (lowPending),
    .ackValid     (ackValid),
    .ackSlot      (ackSlot),
    .ackVector    (ackVector)
  );

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
// Property checker, attached to the top through bind.
module prio_irq_ctrl_chk #(
  parameter int NUM_SLOTS  = 16,
  parameter int ADDR_W     = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  parameter logic [NUM_SLOTS-1:0] POPULATED = 16'h0FFF,
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_SLOTS-1:0] reqIn,
  input logic [NUM_SLOTS-1:0] srcEnable,
  input logic [NUM_SLOTS-1:0] prioHigh,
  input logic                 globalEnable,
  input logic                 cpuReady,
  input logic                 retPulse,
  input logic                 ackValid,
  input logic [IDX_W-1:0]     ackSlot,
  input logic [ADDR_W-1:0]    ackVector,
  input logic                 activeHigh,
  input logic                 activeLow
);

  // Inputs as seen in the arbitration cycle, one cycle before the acknowledge.
  logic [NUM_SLOTS-1:0] prevCand, prevHighCand, prevPrio;
  logic                 prevReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevCand     <= '0;
      prevHighCand <= '0;
      prevPrio     <= '0;
      prevReady    <= 1'b0;
    end else begin
      prevCand     <= reqIn & srcEnable & {NUM_SLOTS{globalEnable}};
      prevHighCand <= reqIn & srcEnable & prioHigh & POPULATED & {NUM_SLOTS{globalEnable}};
      prevPrio     <= prioHigh;
      prevReady    <= cpuReady;
    end
  end

  // R2 R3 R8: the granted slot was requested, enabled and offered while the CPU was ready
  p_grant_legal_r2: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> (prevCand[ackSlot] && prevReady));

  // R4: reserved slots never win
  p_no_reserved_r4: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> POPULATED[ackSlot]);

  // R5: a low-level grant implies no high-level candidate existed
  p_high_first_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && !prevPrio[ackSlot]) |-> (prevHighCand == '0));

  // R7: vector matches slot index
  p_vector_map_r7: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> (ackVector == ADDR_W'(VEC_BASE + VEC_STRIDE * int'(ackSlot))));

  // R9: nothing is granted while a high-level routine runs
  p_high_blocks_r9: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> !$past(activeHigh));

  // R10: during low-level service only a high-level grant is possible
  p_low_preempt_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && $past(activeLow)) |-> (activeHigh && prevPrio[ackSlot]));

  // R11: a return retires the high level first
  p_ret_high_r11: assert property (@(posedge clk) disable iff (!rstN)
    (retPulse && activeHigh) |=> !activeHigh);

  // R11: with only low active, a return retires the low level
  p_ret_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    (retPulse && !activeHigh && activeLow) |=> !activeLow);

  // R12: every acknowledge coincides with an active level
  p_flag_set_r12: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> (activeHigh || activeLow));

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
  .NUM_SLOTS  (NUM_SLOTS),
  .ADDR_W     (ADDR_W),
  .VEC_BASE   (VEC_BASE),
  .VEC_STRIDE (VEC_STRIDE),
  .POPULATED  (POPULATED)
) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .reqIn        (reqIn),
  .srcEnable    (srcEnable),
  .prioHigh     (prioHigh),
  .globalEnable (globalEnable),
  .cpuReady     (cpuReady),
  .retPulse     (retPulse),
  .ackValid     (ackValid),
  .ackSlot      (ackSlot),
  .ackVector    (ackVector),
  .activeHigh   (activeHigh),
  .activeLow    (activeLow)
);

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] reqIn, srcEnable, prioHigh;
  logic        globalEnable, cpuReady, retPulse;
  logic        ackValid;
  logic [3:0]  ackSlot;
  logic [15:0] ackVector;
  logic        activeHigh, activeLow;

  always #5 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk          (clk),
    .rstN         (rstN),
    .reqIn        (reqIn),
    .srcEnable    (srcEnable),
    .prioHigh     (prioHigh),
    .globalEnable (globalEnable),
    .cpuReady     (cpuReady),
    .retPulse     (retPulse),
    .ackValid     (ackValid),
    .ackSlot      (ackSlot),
    .ackVector    (ackVector),
    .activeHigh   (activeHigh),
    .activeLow    (activeLow)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // Behavioural reference model, advanced at each rising edge.
  bit mHigh, mLow, mAck;
  int mSlot;
  int hiW, loW;
  bit accH, accL;

  always @(posedge clk) begin
    if (!rstN) begin
      mHigh = 0; mLow = 0; mAck = 0; mSlot = 0;
    end else begin
      hiW = -1; loW = -1;
      for (int i = 15; i >= 0; i--) begin
        if (reqIn[i] && srcEnable[i] && globalEnable && i < 12) begin
          if (prioHigh[i]) hiW = i; else loW = i;
        end
      end
      accH = cpuReady && hiW >= 0 && !mHigh;
      accL = cpuReady && loW >= 0 && hiW < 0 && !mHigh && !mLow;
      if (retPulse) begin
        if (mHigh) mHigh = 0;
        else if (mLow) mLow = 0;
      end
      if (accH) mHigh = 1;
      if (accL) mLow = 1;
      mAck = accH || accL;
      if (mAck) mSlot = accH ? hiW : loW;
    end
  end

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareModel();
    checkEq("R8 R12 model ack", int'(ackValid), int'(mAck));
    checkEq("R9 R11 R12 model activeHigh", int'(activeHigh), int'(mHigh));
    checkEq("R10 R11 R12 model activeLow", int'(activeLow), int'(mLow));
    if (mAck) begin
      checkEq("R5 R6 model slot", int'(ackSlot), mSlot);
      checkEq("R7 model vector", int'(ackVector), 3 + 8 * mSlot);
    end
  endtask

  // Advance to the next falling edge and compare there.
  task automatic step();
    @(negedge clk);
    compareModel();
  endtask

  task automatic offer(input logic [15:0] req, input logic [15:0] prio);
    reqIn = req; prioHigh = prio; cpuReady = 1'b1;
    step();
    cpuReady = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    rstN = 1'b0; reqIn = '0; srcEnable = '0; prioHigh = '0;
    globalEnable = 1'b0; cpuReady = 1'b0; retPulse = 1'b0;
    repeat (3) @(negedge clk);
    checkEq("R1 ack in reset", int'(ackValid), 0);
    checkEq("R1 high flag in reset", int'(activeHigh), 0);
    checkEq("R1 low flag in reset", int'(activeLow), 0);
    rstN = 1'b1;
    step();
    checkEq("R1 ack after reset", int'(ackValid), 0);

    srcEnable = 16'hFFFF; globalEnable = 1'b1;

    // R6 R7 R12: two low requests, lower index wins
    offer(16'h0014, 16'h0000);
    checkEq("R6 slot", int'(ackSlot), 2);
    checkEq("R7 vector", int'(ackVector), 16'h0013);
    checkEq("R12 low flag", int'(activeLow), 1);
    step();
    checkEq("R8 single pulse", int'(ackValid), 0);

    // R10: low request held off during low service
    offer(16'h0015, 16'h0000);
    checkEq("R10 low blocked", int'(ackValid), 0);
    // R10: high request pre-empts
    offer(16'h0115, 16'h0100);
    checkEq("R10 high pre-empts", int'(ackValid), 1);
    checkEq("R7 vector slot 9", int'(ackVector), 16'h0043);
    checkEq("R12 high flag", int'(activeHigh), 1);

    // R9: nothing during high service
    offer(16'h0117, 16'h0102);
    checkEq("R9 high blocks", int'(ackValid), 0);

    // R11: returns retire high then low
    reqIn = '0;
    retPulse = 1'b1; step(); retPulse = 1'b0;
    checkEq("R11 high retired", int'(activeHigh), 0);
    checkEq("R11 low kept", int'(activeLow), 1);
    retPulse = 1'b1; step(); retPulse = 1'b0;
    checkEq("R11 low retired", int'(activeLow), 0);

    // R5: high beats lower-index low
    offer(16'h0201, 16'h0200);
    checkEq("R5 high wins", int'(ackSlot), 9);
    retPulse = 1'b1; reqIn = '0; step(); retPulse = 1'b0;

    // R3: global enable off
    globalEnable = 1'b0;
    offer(16'h0FFF, 16'h0000);
    checkEq("R3 global off", int'(ackValid), 0);
    globalEnable = 1'b1;

    // R2: per-slot enable off
    srcEnable = 16'hFFF7;
    offer(16'h0008, 16'h0000);
    checkEq("R2 disabled slot", int'(ackValid), 0);
    srcEnable = 16'hFFFF;

    // R4: reserved slots ignored, slot 16 vector unreachable
    offer(16'hF000, 16'hF000);
    checkEq("R4 reserved", int'(ackValid), 0);
    checkEq("R4 no flag", int'(activeHigh), 0);

    // R8: no arbitration without cpuReady
    reqIn = 16'h0001; cpuReady = 1'b0;
    step();
    checkEq("R8 not ready", int'(ackValid), 0);
    offer(16'h0001, 16'h0000);
    checkEq("R7 slot 1 vector", int'(ackVector), 16'h0003);
    reqIn = '0;
    retPulse = 1'b1; step(); retPulse = 1'b0;

    // Random phase, compared against the model on every cycle
    for (int n = 0; n < 2000; n++) begin
      reqIn        = 16'($urandom);
      prioHigh     = 16'($urandom);
      srcEnable    = 16'($urandom) | 16'($urandom);
      globalEnable = ($urandom % 8) != 0;
      cpuReady     = ($urandom % 3) == 0;
      retPulse     = (mHigh || mLow) && (($urandom % 3) == 0);
      step();
    end
    cpuReady = 1'b0; retPulse = 1'b0;
    step();
    finish();
  end

endmodule